// File: doc/BRIEF.md
# Multi-bank selectable clock divider

This block turns one fast source clock into nine divided clock outputs, arranged in four banks of one, one, two and five outputs. Each bank has its own single-bit ratio select. Every ratio is taken from one shared counter, so outputs that run at the same ratio switch on the same cycle. A mode select feeds the counter either from the oscillator input or, in bypass, from the reference input itself. A second select picks which of two reference inputs is used: a single-ended one, or a differential pair.

The block sits in one synchronous clock domain, `clk`, which must be fast enough to oversample every source. Source levels are sampled and their rising edges are detected. Each rising edge steps the shared counter once. Each output is presented as a data bit plus an enable bit. A pad stage, or a bench, turns that pair into a driven level or high impedance. The master reset is synchronous and active high. It clears the counter, forces every data bit low and drops every enable bit.

Top module: `clkdiv_banks`

## Requirements
- R1: Bank A (`q_dat[0]`) divides the selected source by 2 when `div_sel[0]` is 0 and by 4 when it is 1.
- R2: Banks B (`q_dat[1]`), C (`q_dat[3:2]`) and D (`q_dat[8:4]`) divide the source by 4 when their bit of `div_sel` (bit 1, 2 and 3 respectively) is 0 and by 8 when it is 1. Each bit controls only its own bank.
- R3: All outputs of one bank are equal in every cycle. Outputs at the same ratio rise in the same cycle. After master reset is released, all nine outputs make their first rise in the same cycle.
- R4: Within one `clk` cycle after `mr` is sampled high, every `q_oe` bit is 0 and every `q_dat` bit is 0. The counter is held cleared while `mr` is high. One cycle after `mr` is sampled low, every `q_oe` bit is 1.
- R5: With `mode_sel` = 1 the counter steps once per rising edge of `osc_in`. With `mode_sel` = 0 it steps once per rising edge of the selected reference (bypass).
- R6: With `in_sel` = 1 the reference is `ref_se`. With `in_sel` = 0 the reference is the differential pair, which reads high when `ref_dp` = 1 and `ref_dn` = 0, and low otherwise.
- R7: A change of a bank's select bit takes effect only when the counter is at zero. An output therefore never produces a high or low phase shorter than half its old or new period.
- R8: Every output has a 50% duty cycle: its high and low phases each last ratio/2 source periods.
- R9: With every control input at 0, the block runs in bypass from the differential reference, with bank A at /2, banks B, C and D at /4, and all outputs enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the whole block |
| mr | input | 1 | Master reset, synchronous, active high; clears the counter and disables the outputs |
| mode_sel | input | 1 | 1: counter fed from the oscillator; 0: bypass, fed from the reference |
| in_sel | input | 1 | 1: single-ended reference; 0: differential reference |
| osc_in | input | 1 | Oscillator clock level |
| ref_se | input | 1 | Single-ended reference level |
| ref_dp | input | 1 | Differential reference, true leg |
| ref_dn | input | 1 | Differential reference, complement leg |
| div_sel | input | 4 | Ratio select per bank: bit 0 bank A, bit 1 bank B, bit 2 bank C, bit 3 bank D |
| q_dat | output | 9 | Output data: bit 0 A, bit 1 B, bits 3:2 C, bits 8:4 D |
| q_oe | output | 9 | Output enable per output, same bit order as `q_dat` |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a master reset and a counter step from a source edge. The bench raises `mr` at four different phase offsets from the source edges. It expects every output cleared and disabled one cycle later. After each release it expects all nine outputs to rise together. The second pair is a select change and the counter's pass through zero. The bench flips a bank's select at several offsets inside the output period, in both directions. It then records eight consecutive phase lengths and accepts only lengths of the old or the new ratio, with the old ones never following a new one.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int MAX_DIV   = 8;
  localparam int CNT_W     = $clog2(MAX_DIV);
  localparam int NUM_BANKS = 4;

  typedef enum logic {
    SRC_REF = 1'b0,
    SRC_OSC = 1'b1
  } src_mode_e;

  // Counter bit that gives a bank's ratio when its select is 0; the bit
  // above it gives the ratio for select 1.
  function automatic int lo_tap(input int bank);
    return (bank == 0) ? 0 : 1;
  endfunction
endpackage

// File: rtl/clkdiv_src_pick.sv
module clkdiv_src_pick (
  input  logic clk,
  input  logic mr,
  input  logic mode_sel,
  input  logic in_sel,
  input  logic osc_in,
  input  logic ref_se,
  input  logic ref_dp,
  input  logic ref_dn,
  output logic adv
);
  import clkdiv_pkg::*;

  src_mode_e  mode;
  logic       ref_lvl;
  logic       src_lvl;
  logic [1:0] smp;   // smp[0] newest sample

  always_comb begin
    mode    = src_mode_e'(mode_sel);
    ref_lvl = in_sel ? ref_se : (ref_dp & ~ref_dn);
    src_lvl = (mode == SRC_OSC) ? osc_in : ref_lvl;
  end

  // Reset to all ones so that a source sitting high at release is not taken as an edge
  always_ff @(posedge clk) begin
    if (mr) smp <= 2'b11;
    else    smp <= {smp[0], src_lvl};
  end

  assign adv = smp[0] & ~smp[1];

  p_adv_isolated_r5: assert property (@(posedge clk) disable iff (mr)
    adv |=> !adv);

  p_adv_after_high_r5: assert property (@(posedge clk) disable iff (mr)
    adv |-> $past(src_lvl));
endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain #(
  parameter int CNT_W = clkdiv_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             mr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt,
  output logic             at_zero
);
  // Down counter: leaving zero sets every bit at once, so all taps rise together
  always_ff @(posedge clk) begin
    if (mr)       cnt <= '0;
    else if (adv) cnt <= cnt - 1'b1;
  end

  assign at_zero = (cnt == '0);

  p_reset_clears_r4: assert property (@(posedge clk)
    mr |=> (cnt == '0));

  p_hold_without_edge_r5: assert property (@(posedge clk) disable iff (mr)
    !adv |=> $stable(cnt));

  p_taps_rise_together_r3: assert property (@(posedge clk) disable iff (mr)
    $rose(cnt[CNT_W-1]) |-> (cnt == '1));
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             mr,
  input  logic             sel,
  input  logic             tap_lo,
  input  logic             tap_hi,
  input  logic             at_zero,
  output logic [WIDTH-1:0] q_dat,
  output logic [WIDTH-1:0] q_oe
);
  logic sel_eff;
  logic tap;

  // The select is taken only while the counter sits at zero, when both taps are low
  always_ff @(posedge clk) begin
    if (mr || at_zero) sel_eff <= sel;
  end

  assign tap = sel_eff ? tap_hi : tap_lo;

  // One register per output pin, as a clock fan-out tree would have
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (mr) begin
        q_dat[i] <= 1'b0;
        q_oe[i]  <= 1'b0;
      end else begin
        q_dat[i] <= tap;
        q_oe[i]  <= 1'b1;
      end
    end
  end

  p_sel_only_at_zero_r7: assert property (@(posedge clk) disable iff (mr)
    !$stable(sel_eff) |-> ($past(at_zero) || $past(mr)));

  p_out_quiet_in_reset_r4: assert property (@(posedge clk)
    mr |=> (q_dat == '0 && q_oe == '0));
endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks #(
  parameter int A_W = 1,
  parameter int B_W = 1,
  parameter int C_W = 2,
  parameter int D_W = 5,
  localparam int OUT_N = A_W + B_W + C_W + D_W
) (
  input  logic                         clk,
  input  logic                         mr,
  input  logic                         mode_sel,
  input  logic                         in_sel,
  input  logic                         osc_in,
  input  logic                         ref_se,
  input  logic                         ref_dp,
  input  logic                         ref_dn,
  input  logic [clkdiv_pkg::NUM_BANKS-1:0] div_sel,
  output logic [OUT_N-1:0]             q_dat,
  output logic [OUT_N-1:0]             q_oe
);
  import clkdiv_pkg::*;

  localparam int BW [NUM_BANKS] = '{A_W, B_W, C_W, D_W};

  logic             adv;
  logic [CNT_W-1:0] cnt;
  logic             at_zero;

  clkdiv_src_pick u_src (
    .clk      (clk),
    .mr       (mr),
    .mode_sel (mode_sel),
    .in_sel   (in_sel),
    .osc_in   (osc_in),
    .ref_se   (ref_se),
    .ref_dp   (ref_dp),
    .ref_dn   (ref_dn),
    .adv      (adv)
  );

  clkdiv_chain #(.CNT_W(CNT_W)) u_chain (
    .clk     (clk),
    .mr      (mr),
    .adv     (adv),
    .cnt     (cnt),
    .at_zero (at_zero)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int W   = BW[b];
    localparam int OFS = ((b > 0) ? BW[0] : 0) + ((b > 1) ? BW[1] : 0) + ((b > 2) ? BW[2] : 0);
    localparam int LO  = lo_tap(b);

    clkdiv_bank #(.WIDTH(W)) u_bank (
      .clk     (clk),
      .mr      (mr),
      .sel     (div_sel[b]),
      .tap_lo  (cnt[LO]),
      .tap_hi  (cnt[LO+1]),
      .at_zero (at_zero),
      .q_dat   (q_dat[OFS +: W]),
      .q_oe    (q_oe[OFS +: W])
    );
  end

  p_bank_d_uniform_r3: assert property (@(posedge clk) disable iff (mr)
    ($countones(q_dat[OUT_N-1 -: D_W]) == 0) || ($countones(q_dat[OUT_N-1 -: D_W]) == D_W));

  p_enable_after_release_r4: assert property (@(posedge clk) disable iff (mr)
    $fell(mr) |-> (q_oe == '0 && q_dat == '0));
endmodule

// File: tb/clkdiv_banks_test.sv
module clkdiv_banks_test;
  localparam int H_OSC = 2;
  localparam int H_SE  = 3;
  localparam int H_DIF = 5;
  localparam int WD    = 2000;

  logic       clk = 1'b0;
  logic       mr = 1'b1;
  logic       mode_sel = 1'b0;
  logic       in_sel = 1'b0;
  logic       osc = 1'b0;
  logic       se = 1'b0;
  logic       dp = 1'b0;
  logic       dn;
  logic [3:0] div_sel = 4'b0000;
  logic [8:0] q_dat;
  logic [8:0] q_oe;

  int nchk  = 0;
  int nfail = 0;
  int rl [8];

  assign dn = ~dp;

  clkdiv_banks uut (
    .clk(clk), .mr(mr), .mode_sel(mode_sel), .in_sel(in_sel),
    .osc_in(osc), .ref_se(se), .ref_dp(dp), .ref_dn(dn),
    .div_sel(div_sel), .q_dat(q_dat), .q_oe(q_oe)
  );

  always #10 clk = ~clk;

  // Source generators, stepping on falling clock edges
  initial begin
    int co = 0;
    int cs = 0;
    int cd = 0;
    forever begin
      @(negedge clk);
      co++; cs++; cd++;
      if (co == H_OSC) begin osc = ~osc; co = 0; end
      if (cs == H_SE)  begin se  = ~se;  cs = 0; end
      if (cd == H_DIF) begin dp  = ~dp;  cd = 0; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Record n consecutive phase lengths of output idx, starting at its next transition
  task automatic get_runs(input int idx, input int n);
    logic cur;
    int   t = 0;
    @(negedge clk);
    cur = q_dat[idx];
    while (q_dat[idx] == cur && t < WD) begin @(negedge clk); t++; end
    cur = q_dat[idx];
    for (int k = 0; k < n; k++) begin
      rl[k] = 0;
      while (q_dat[idx] == cur && t < WD) begin rl[k]++; @(negedge clk); t++; end
      cur = q_dat[idx];
    end
    if (t >= WD) chk(1'b0, "timeout waiting for output phases", t, WD);
  endtask

  task automatic chk_runs(input int idx, input int exp, input string tag);
    get_runs(idx, 3);
    for (int k = 0; k < 3; k++)
      chk(rl[k] == exp, $sformatf("%s phase length of output %0d", tag, idx), rl[k], exp);
    chk(rl[1] == rl[2], $sformatf("R8 duty of output %0d", idx), rl[1], rl[2]);
  endtask

  // Release reset and check that all nine outputs rise first in the same cycle
  task automatic release_and_align(input string tag);
    int first [9];
    for (int b = 0; b < 9; b++) first[b] = -1;
    mr = 1'b0;
    @(negedge clk);
    chk(q_oe == 9'h1FF, {tag, " R4 enables after release"}, int'(q_oe), 9'h1FF);
    chk(q_dat == 9'h000, {tag, " R4 data low at release"}, int'(q_dat), 0);
    for (int c = 0; c < 200; c++) begin
      for (int b = 0; b < 9; b++) if (q_dat[b] && first[b] < 0) first[b] = c;
      @(negedge clk);
    end
    for (int b = 1; b < 9; b++)
      chk(first[b] == first[0] && first[0] >= 0, {tag, " R3 first rise aligned"}, first[b], first[0]);
  endtask

  task automatic t_reset;
    idle(5);
    chk(q_oe == 9'h000, "R4 enables low in reset", int'(q_oe), 0);
    chk(q_dat == 9'h000, "R4 data low in reset", int'(q_dat), 0);
  endtask

  task automatic t_defaults;
    release_and_align("R9 default");
    idle(100);
    chk_runs(0, 2 * H_DIF, "R9 R1 bank A /2 bypass diff");
    chk_runs(1, 4 * H_DIF, "R9 R2 bank B /4");
    chk_runs(3, 4 * H_DIF, "R9 R2 bank C /4");
    chk_runs(8, 4 * H_DIF, "R9 R2 bank D /4");
  endtask

  task automatic t_osc_mode;
    mode_sel = 1'b1;
    idle(120);
    chk_runs(0, 2 * H_OSC, "R5 oscillator feeds A /2");
    div_sel = 4'b0001;
    idle(120);
    chk_runs(0, 4 * H_OSC, "R1 bank A /4");
  endtask

  task automatic t_independent;
    logic bad_c = 1'b0;
    logic bad_d = 1'b0;
    div_sel = 4'b1010;
    idle(120);
    chk_runs(0, 2 * H_OSC, "R2 bank A unaffected");
    chk_runs(1, 8 * H_OSC, "R2 bank B /8");
    chk_runs(2, 4 * H_OSC, "R2 bank C /4");
    chk_runs(5, 8 * H_OSC, "R2 bank D /8");
    for (int c = 0; c < 100; c++) begin
      if (q_dat[3:2] != {2{q_dat[2]}}) bad_c = 1'b1;
      if (q_dat[8:4] != {5{q_dat[4]}}) bad_d = 1'b1;
      @(negedge clk);
    end
    chk(!bad_c, "R3 bank C outputs equal", int'(bad_c), 0);
    chk(!bad_d, "R3 bank D outputs equal", int'(bad_d), 0);
  endtask

  task automatic t_input_sel;
    div_sel  = 4'b0000;
    mode_sel = 1'b0;
    in_sel   = 1'b1;
    idle(150);
    chk_runs(0, 2 * H_SE, "R6 single-ended reference");
    in_sel = 1'b0;
    idle(150);
    chk_runs(0, 2 * H_DIF, "R6 differential reference");
    chk_runs(1, 4 * H_DIF, "R5 bypass bank B");
  endtask

  // Flip bank B's select at an offset into its period; all phases must be legal
  task automatic t_switch(input logic to_hi, input int offset);
    int  old_len = to_hi ? 4 * H_OSC : 8 * H_OSC;
    int  new_len = to_hi ? 8 * H_OSC : 4 * H_OSC;
    bit  legal = 1'b1;
    bit  seen_new = 1'b0;
    bit  order_ok = 1'b1;
    int  bad_len = 0;
    div_sel  = {2'b00, ~to_hi, 1'b0};
    idle(120);
    while (q_dat[1] != 1'b1) @(negedge clk);
    idle(offset);
    div_sel[1] = to_hi;
    get_runs(1, 8);
    for (int k = 0; k < 8; k++) begin
      if (rl[k] != old_len && rl[k] != new_len) begin legal = 1'b0; bad_len = rl[k]; end
      if (rl[k] == new_len) seen_new = 1'b1;
      else if (seen_new) order_ok = 1'b0;
    end
    chk(legal, $sformatf("R7 no runt after switch at offset %0d", offset), bad_len, new_len);
    chk(order_ok, "R7 new ratio holds once taken", int'(order_ok), 1);
    chk(rl[7] == new_len, "R7 settles to new ratio", rl[7], new_len);
  endtask

  // Raise master reset at several phases against the source edges
  task automatic t_mr_mid;
    div_sel = 4'b0110;
    for (int off = 0; off < 4; off++) begin
      idle(37 + off);
      mr = 1'b1;
      @(negedge clk);
      chk(q_oe == 9'h000, "R4 outputs disabled one cycle after reset", int'(q_oe), 0);
      chk(q_dat == 9'h000, "R4 data cleared one cycle after reset", int'(q_dat), 0);
      idle(6);
      chk(q_oe == 9'h000 && q_dat == 9'h000, "R4 outputs stay quiet in reset", int'(q_dat), 0);
      release_and_align("mid-run");
    end
  endtask

  initial begin
    t_reset();
    t_defaults();
    t_osc_mode();
    t_independent();
    t_input_sel();
    mode_sel = 1'b1;
    t_switch(1'b1, 1);
    t_switch(1'b1, 5);
    t_switch(1'b0, 3);
    t_switch(1'b0, 11);
    t_mr_mid();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule